// File: doc/BRIEF.md
# Prioritized Interleaved Memory Arbiter

This block arbitrates access to a set of interleaved memory modules on behalf of a group of requesters, all of which share one link to the memory. Requesters are sorted into three fixed priority classes. The top class is split into two sub-groups, and the arbiter alternates between them. Within a group, requesters take turns in a rotating order. Up to two accesses may be in flight at once, provided they target different modules.

A requester posts an access with a one-cycle valid pulse that carries a byte address and a write flag. The arbiter holds that access as pending. When the access wins, the arbiter pulses the start line of the target module, drives the module's address and write flag, and raises the requester's grant. The grant stays high until the module reports that its cycle is complete. At that point the grant drops and the requester receives a one-cycle done pulse.

The target module comes from the low word-address bits, so consecutive words fall on alternating odd and even modules and can overlap.

Top module: `ilv_mem_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, every grant, done and module start output is low.
- R2: A valid pulse is captured at a clock edge only if that requester has no pending or granted access. Otherwise the pulse is ignored, and the address and write flag captured earlier are the ones presented to the module. The earliest grant is visible two edges after the pulse.
- R3: The target module is address bits [2 +: log2(modules)]: bit 2 for two modules, bits 3:2 for four. A grant pulses that module's start for one cycle and drives that module's address and write outputs with the captured values.
- R4: A module receives no start while its busy input is high, or while it is still held by an access in flight.
- R5: At most two accesses are granted at once, at most one new grant is made per cycle, and in-flight accesses always target distinct modules.
- R6: Among eligible requesters, class 1 (indices 0 to 3) wins over class 2 (indices 4 to 7), and class 2 wins over class 3 (index 8).
- R7: Within a group, the search starts at the index after the group's last winner and wraps around. After reset, the search starts at the group's lowest index.
- R8: Class 1 sub-group A (indices 0 and 1) and sub-group B (indices 2 and 3) alternate when both have eligible requesters. After reset, A is favoured. After a grant to one sub-group, the other is favoured.
- R9: A requester that is skipped because its module is unavailable stays pending. Its group's rotation point moves only when a grant is made. The requester is granted once its module frees.
- R10: A grant stays high from the cycle its start pulse is visible until the edge after the module's done input. In that cycle the grant is low and the requester's done output pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | NUM_REQ | One-cycle access request pulse per requester |
| req_addr_i | input | NUM_REQ*AW | Byte address per requester, packed |
| req_we_i | input | NUM_REQ | Write flag per requester |
| grant_o | output | NUM_REQ | Access in flight for the requester |
| done_o | output | NUM_REQ | One-cycle completion pulse per requester |
| mod_busy_i | input | NUM_MOD | Module cannot accept a new cycle |
| mod_done_i | input | NUM_MOD | Module cycle complete |
| mod_start_o | output | NUM_MOD | One-cycle cycle-start pulse per module |
| mod_addr_o | output | NUM_MOD*AW | Address presented to each module, packed |
| mod_we_o | output | NUM_MOD | Write flag presented to each module |

## Verification
The assertions check the following on every cycle:
- no start goes to a busy module;
- never more than one start per cycle, and never more than two grants at once;
- a grant only rises together with a start;
- a grant only falls together with its done pulse.

The choice of winner, by class, sub-group alternation and rotation, can only be seen in the bench's scenarios. The same holds for the module decode, the discarding of repeated requests, and the recovery of a requester that was blocked by a busy module. In those scenarios, the reference model and the directed checks compare who wins and when.

// File: rtl/ilv_arb_pkg.sv
package ilv_arb_pkg;
    localparam int NUM_SLOT = 2;
    localparam int NUM_GRP  = 4;

    typedef enum logic [1:0] {
        GRP_1A = 2'd0,
        GRP_1B = 2'd1,
        GRP_2  = 2'd2,
        GRP_3  = 2'd3
    } grp_e;
endpackage

// File: rtl/ilv_rr_pick.sv
module ilv_rr_pick #(
    parameter int N  = 9,
    parameter int IW = 4,
    parameter logic [N-1:0] MEMBERS = '1
) (
    input  logic [N-1:0]  elig_i,
    input  logic [IW-1:0] last_i,
    output logic          found_o,
    output logic [IW-1:0] pick_o
);
    // Walk the ring starting one past the last winner; first member hit wins.
    always_comb begin
        found_o = 1'b0;
        pick_o  = last_i;
        for (int off = 1; off <= N; off++) begin
            int c;
            c = (int'(last_i) + off) % N;
            if (!found_o && elig_i[c] && MEMBERS[c]) begin
                found_o = 1'b1;
                pick_o  = IW'(c);
            end
        end
    end
endmodule

// File: rtl/ilv_mod_decode.sv
module ilv_mod_decode #(
    parameter int AW = 18,
    parameter int MW = 2
) (
    input  logic [AW-1:0] addr_i,
    output logic [MW-1:0] mod_o
);
    // Drop the byte offset; the lowest word bits steer the module.
    assign mod_o = addr_i[2 +: MW];
endmodule

// File: rtl/ilv_mem_arbiter.sv
module ilv_mem_arbiter
    import ilv_arb_pkg::*;
#(
    parameter int AW      = 18,
    parameter int NUM_MOD = 4,
    parameter int N_1A    = 2,
    parameter int N_1B    = 2,
    parameter int N_2     = 4,
    parameter int N_3     = 1
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [N_1A+N_1B+N_2+N_3-1:0]             req_valid_i,
    input  logic [(N_1A+N_1B+N_2+N_3)*AW-1:0]        req_addr_i,
    input  logic [N_1A+N_1B+N_2+N_3-1:0]             req_we_i,
    output logic [N_1A+N_1B+N_2+N_3-1:0]             grant_o,
    output logic [N_1A+N_1B+N_2+N_3-1:0]             done_o,
    input  logic [NUM_MOD-1:0]                       mod_busy_i,
    input  logic [NUM_MOD-1:0]                       mod_done_i,
    output logic [NUM_MOD-1:0]                       mod_start_o,
    output logic [NUM_MOD*AW-1:0]                    mod_addr_o,
    output logic [NUM_MOD-1:0]                       mod_we_o
);
    localparam int NUM_REQ = N_1A + N_1B + N_2 + N_3;
    localparam int RW      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam int MW      = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1;
    localparam int B_1B    = N_1A;
    localparam int B_2     = N_1A + N_1B;
    localparam int B_3     = N_1A + N_1B + N_2;

    localparam logic [NUM_REQ-1:0] M_1A = NUM_REQ'((1 << N_1A) - 1);
    localparam logic [NUM_REQ-1:0] M_1B = NUM_REQ'(((1 << N_1B) - 1) << B_1B);
    localparam logic [NUM_REQ-1:0] M_2  = NUM_REQ'(((1 << N_2) - 1) << B_2);
    localparam logic [NUM_REQ-1:0] M_3  = NUM_REQ'(((1 << N_3) - 1) << B_3);
    localparam logic [NUM_GRP-1:0][NUM_REQ-1:0] GMASK = {M_3, M_2, M_1B, M_1A};

    // Last-winner reset value: the group's top index, so the first search hits its lowest.
    localparam logic [NUM_GRP-1:0][RW-1:0] PTR_RST = {
        RW'(B_3 + N_3 - 1), RW'(B_2 + N_2 - 1), RW'(B_1B + N_1B - 1), RW'(N_1A - 1)
    };

    typedef struct packed {
        logic [NUM_REQ-1:0]               pend;
        logic [NUM_REQ-1:0][AW-1:0]       addr;
        logic [NUM_REQ-1:0]               we;
        logic [NUM_SLOT-1:0]              sv;
        logic [NUM_SLOT-1:0][RW-1:0]      sreq;
        logic [NUM_SLOT-1:0][MW-1:0]      smod;
        logic [NUM_GRP-1:0][RW-1:0]       ptr;
        logic                             favor_b;
        logic [NUM_MOD-1:0]               start;
        logic [NUM_MOD-1:0][AW-1:0]       maddr;
        logic [NUM_MOD-1:0]               mwe;
        logic [NUM_REQ-1:0]               done;
    } state_t;

    state_t st_d, st_q;

    logic [MW-1:0]        req_mod [NUM_REQ];
    logic [NUM_MOD-1:0]   held;
    logic [NUM_REQ-1:0]   in_srv;
    logic [NUM_REQ-1:0]   elig;
    logic                 free_any;
    logic [NUM_GRP-1:0]   found;
    logic [RW-1:0]        pick [NUM_GRP];
    logic                 any_win;
    logic [1:0]           win_grp;
    logic [RW-1:0]        win;
    logic                 slot_sel;

    // Module decode per requester from the captured address
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_dec
        ilv_mod_decode #(.AW(AW), .MW(MW)) u_dec (
            .addr_i (st_q.addr[i]),
            .mod_o  (req_mod[i])
        );
    end

    // Slot occupancy: which modules and requesters are tied up
    always_comb begin
        held   = '0;
        in_srv = '0;
        for (int s = 0; s < NUM_SLOT; s++) begin
            if (st_q.sv[s]) begin
                held[st_q.smod[s]]  = 1'b1;
                in_srv[st_q.sreq[s]] = 1'b1;
            end
        end
    end

    assign free_any = ~&st_q.sv;
    assign slot_sel = st_q.sv[0];

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_elig
        assign elig[i] = st_q.pend[i] & ~mod_busy_i[req_mod[i]]
                       & ~held[req_mod[i]] & free_any;
    end

    // One rotating picker per priority group
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pick
        ilv_rr_pick #(.N(NUM_REQ), .IW(RW), .MEMBERS(GMASK[g])) u_pick (
            .elig_i  (elig),
            .last_i  (st_q.ptr[g]),
            .found_o (found[g]),
            .pick_o  (pick[g])
        );
    end

    // Class resolution: class 1 sub-groups alternate, then class 2, then class 3
    always_comb begin
        any_win = |found;
        if (found[GRP_1A] || found[GRP_1B]) begin
            if (found[GRP_1B] && (!found[GRP_1A] || st_q.favor_b)) begin
                win_grp = GRP_1B;
            end else begin
                win_grp = GRP_1A;
            end
        end else if (found[GRP_2]) begin
            win_grp = GRP_2;
        end else begin
            win_grp = GRP_3;
        end
        win = pick[win_grp];
    end

    // Next-state
    always_comb begin
        st_d       = st_q;
        st_d.start = '0;
        st_d.done  = '0;

        for (int s = 0; s < NUM_SLOT; s++) begin
            if (st_q.sv[s] && mod_done_i[st_q.smod[s]]) begin
                st_d.sv[s]               = 1'b0;
                st_d.done[st_q.sreq[s]]  = 1'b1;
            end
        end

        for (int i = 0; i < NUM_REQ; i++) begin
            if (req_valid_i[i] && !st_q.pend[i] && !in_srv[i]) begin
                st_d.pend[i] = 1'b1;
                st_d.addr[i] = req_addr_i[i*AW +: AW];
                st_d.we[i]   = req_we_i[i];
            end
        end

        if (any_win) begin
            st_d.sv[slot_sel]         = 1'b1;
            st_d.sreq[slot_sel]       = win;
            st_d.smod[slot_sel]       = req_mod[win];
            st_d.pend[win]            = 1'b0;
            st_d.ptr[win_grp]         = win;
            if (win_grp == GRP_1A) st_d.favor_b = 1'b1;
            if (win_grp == GRP_1B) st_d.favor_b = 1'b0;
            st_d.start[req_mod[win]]  = 1'b1;
            st_d.maddr[req_mod[win]]  = st_q.addr[win];
            st_d.mwe[req_mod[win]]    = st_q.we[win];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ptr <= PTR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o     = in_srv;
    assign done_o      = st_q.done;
    assign mod_start_o = st_q.start;
    assign mod_we_o    = st_q.mwe;
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mout
        assign mod_addr_o[m*AW +: AW] = st_q.maddr[m];
    end
endmodule

// File: rtl/ilv_mem_arbiter_chk.sv
module ilv_mem_arbiter_chk #(
    parameter int NUM_REQ = 9,
    parameter int NUM_MOD = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] grant_o,
    input logic [NUM_REQ-1:0] done_o,
    input logic [NUM_MOD-1:0] mod_busy_i,
    input logic [NUM_MOD-1:0] mod_start_o
);
    assert_one_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_start_o));

    assert_two_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= 2);

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_m
        assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
            mod_start_o[m] |-> $past(!mod_busy_i[m]));
    end

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_r
        assert_rise_with_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant_o[i]) |-> (|mod_start_o));
        assert_fall_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(grant_o[i]) |-> done_o[i]);
        assert_done_after_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
            done_o[i] |-> (!grant_o[i] && $past(grant_o[i])));
    end
endmodule

bind ilv_mem_arbiter ilv_mem_arbiter_chk #(
    .NUM_REQ (N_1A + N_1B + N_2 + N_3),
    .NUM_MOD (NUM_MOD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_o     (grant_o),
    .done_o      (done_o),
    .mod_busy_i  (mod_busy_i),
    .mod_start_o (mod_start_o)
);

// File: tb/ilv_mem_arbiter_bench.sv
module ilv_mem_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 18;
    localparam int NR  = 9;
    localparam int NM  = 4;
    localparam int LAT = 5;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NR-1:0]     req_valid;
    logic [NR*AW-1:0]  req_addr;
    logic [NR-1:0]     req_we;
    logic [NR-1:0]     grant;
    logic [NR-1:0]     done;
    logic [NM-1:0]     mbusy;
    logic [NM-1:0]     mdone;
    logic [NM-1:0]     mstart;
    logic [NM*AW-1:0]  maddr;
    logic [NM-1:0]     mwe;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int start_cnt = 0;

    // bench-side memory model and forced busy
    int cnt [NM];
    bit fbusy [NM];

    // reference model state
    bit m_pend [NR];
    int m_addr [NR];
    bit m_we   [NR];
    bit m_sv   [2];
    int m_sreq [2];
    int m_smod [2];
    int m_ptr  [4];
    bit m_fav;
    bit e_start [NM];
    int e_addr  [NM];
    bit e_we    [NM];
    bit e_done  [NR];

    ilv_mem_arbiter u_ilv_mem_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_addr_i  (req_addr),
        .req_we_i    (req_we),
        .grant_o     (grant),
        .done_o      (done),
        .mod_busy_i  (mbusy),
        .mod_done_i  (mdone),
        .mod_start_o (mstart),
        .mod_addr_o  (maddr),
        .mod_we_o    (mwe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int modof(int a);
        return (a >> 2) & 3;
    endfunction

    function automatic int grpof(int i);
        if (i < 2) return 0;
        if (i < 4) return 1;
        if (i < 8) return 2;
        return 3;
    endfunction

    task automatic chk(string tag, bit ok, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic post(int i, int a, bit w);
        req_valid[i] = 1'b1;
        req_addr[i*AW +: AW] = AW'(a);
        req_we[i] = w;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin
            m_pend[i] = 0; m_addr[i] = 0; m_we[i] = 0; e_done[i] = 0;
        end
        for (int s = 0; s < 2; s++) begin
            m_sv[s] = 0; m_sreq[s] = 0; m_smod[s] = 0;
        end
        m_ptr[0] = 1; m_ptr[1] = 3; m_ptr[2] = 7; m_ptr[3] = 8;
        m_fav = 0;
        for (int m = 0; m < NM; m++) begin
            e_start[m] = 0; e_addr[m] = 0; e_we[m] = 0; cnt[m] = 0; fbusy[m] = 0;
        end
    endtask

    // Reference step, applied with the inputs about to be sampled at the next edge
    task automatic model_step();
        bit p_o [NR];
        int a_o [NR];
        bit w_o [NR];
        bit sv_o [2];
        int sq_o [2];
        int sm_o [2];
        int pt_o [4];
        bit srv [NR];
        bit hld [NM];
        int cand [4];
        int wg;
        p_o = m_pend; a_o = m_addr; w_o = m_we;
        sv_o = m_sv; sq_o = m_sreq; sm_o = m_smod; pt_o = m_ptr;
        for (int i = 0; i < NR; i++) begin srv[i] = 0; e_done[i] = 0; end
        for (int m = 0; m < NM; m++) begin hld[m] = 0; e_start[m] = 0; end
        for (int s = 0; s < 2; s++) if (sv_o[s]) begin srv[sq_o[s]] = 1; hld[sm_o[s]] = 1; end

        for (int s = 0; s < 2; s++) begin
            if (sv_o[s] && mdone[sm_o[s]]) begin
                m_sv[s] = 0;
                e_done[sq_o[s]] = 1;
            end
        end
        for (int i = 0; i < NR; i++) begin
            if (req_valid[i] && !p_o[i] && !srv[i]) begin
                m_pend[i] = 1;
                m_addr[i] = int'(req_addr[i*AW +: AW]);
                m_we[i]   = req_we[i];
            end
        end
        if (!sv_o[0] || !sv_o[1]) begin
            for (int g = 0; g < 4; g++) begin
                cand[g] = -1;
                for (int off = 1; off <= NR; off++) begin
                    int c;
                    c = (pt_o[g] + off) % NR;
                    if (grpof(c) == g && p_o[c] && !mbusy[modof(a_o[c])] && !hld[modof(a_o[c])]) begin
                        cand[g] = c;
                        break;
                    end
                end
            end
            if (cand[0] >= 0 && cand[1] >= 0) wg = m_fav ? 1 : 0;
            else if (cand[0] >= 0) wg = 0;
            else if (cand[1] >= 0) wg = 1;
            else if (cand[2] >= 0) wg = 2;
            else if (cand[3] >= 0) wg = 3;
            else wg = -1;
            if (wg >= 0) begin
                int w;
                int s;
                int md;
                w = cand[wg];
                s = sv_o[0] ? 1 : 0;
                md = modof(a_o[w]);
                m_sv[s] = 1; m_sreq[s] = w; m_smod[s] = md;
                m_pend[w] = 0;
                m_ptr[wg] = w;
                if (wg == 0) m_fav = 1;
                if (wg == 1) m_fav = 0;
                e_start[md] = 1; e_addr[md] = a_o[w]; e_we[md] = w_o[w];
            end
        end
    endtask

    task automatic compare();
        bit ok;
        logic [NR-1:0] eg;
        logic [NR-1:0] ed;
        logic [NM-1:0] es;
        eg = '0; ed = '0; es = '0;
        for (int s = 0; s < 2; s++) if (m_sv[s]) eg[m_sreq[s]] = 1'b1;
        for (int i = 0; i < NR; i++) ed[i] = e_done[i];
        for (int m = 0; m < NM; m++) es[m] = e_start[m];
        ok = (grant === eg);
        chk("R6 R7 R8 R9 grant vector vs model", ok, int'(grant), int'(eg));
        ok = (done === ed);
        chk("R10 done vector vs model", ok, int'(done), int'(ed));
        ok = (mstart === es);
        chk("R3 R4 start vector vs model", ok, int'(mstart), int'(es));
        for (int m = 0; m < NM; m++) begin
            if (es[m]) begin
                ok = (int'(maddr[m*AW +: AW]) == e_addr[m]) && (mwe[m] === e_we[m]);
                chk("R3 module address/write vs model", ok, int'(maddr[m*AW +: AW]), e_addr[m]);
            end
        end
        ok = ($countones(grant) <= 2);
        chk("R5 in-flight bound", ok, $countones(grant), 2);
    endtask

    task automatic tick();
        for (int m = 0; m < NM; m++) begin
            mdone[m] = (cnt[m] == 1);
            mbusy[m] = (cnt[m] > 0) || fbusy[m];
        end
        model_step();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        compare();
        for (int m = 0; m < NM; m++) begin
            if (cnt[m] > 0) cnt[m]--;
            if (mstart[m]) begin
                cnt[m] = LAT;
                start_cnt++;
            end
        end
        req_valid = '0;
    endtask

    task automatic wait_grant(output int who);
        logic [NR-1:0] prev;
        logic [NR-1:0] nb;
        prev = grant;
        who = -1;
        for (int k = 0; k < 60; k++) begin
            tick();
            nb = grant & ~prev;
            prev = grant;
            if (nb != '0) begin
                for (int i = 0; i < NR; i++) if (nb[i]) who = i;
                break;
            end
        end
    endtask

    task automatic drain();
        repeat (20) tick();
    endtask

    initial begin
        int who;
        int n;
        rst_n = 1'b0;
        req_valid = '0; req_addr = '0; req_we = '0;
        mbusy = '0; mdone = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 grant in reset", grant === '0, int'(grant), 0);
        chk("R1 start in reset", mstart === '0, int'(mstart), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 outputs after reset", (grant === '0) && (done === '0) && (mstart === '0), int'(grant), 0);

        // R3 and R10: single class-3 write to word 3 (module 3)
        post(8, 'h0C, 1'b1);
        wait_grant(who);
        chk("R3 winner", who == 8, who, 8);
        chk("R3 start on module 3", mstart === 4'b1000, int'(mstart), 8);
        chk("R3 address on module 3", maddr[3*AW +: AW] == AW'('h0C) && mwe[3] == 1'b1,
            int'(maddr[3*AW +: AW]), 'h0C);
        n = 0;
        while (!done[8] && n < 40) begin tick(); n++; end
        chk("R10 done after module latency", n == LAT, n, LAT);
        chk("R10 grant low with done", grant[8] == 1'b0, int'(grant[8]), 0);
        drain();

        // R6: one requester from each class on distinct modules
        post(8, 'h08, 1'b0); post(4, 'h04, 1'b0); post(0, 'h00, 1'b0);
        wait_grant(who); chk("R6 class 1 first", who == 0, who, 0);
        wait_grant(who); chk("R6 class 2 second", who == 4, who, 4);
        wait_grant(who); chk("R6 class 3 last", who == 8, who, 8);
        drain();

        // R7: rotation inside class 2 (last winner 4)
        post(4, 'h00, 1'b0); post(5, 'h00, 1'b0);
        wait_grant(who); chk("R7 after last winner 4", who == 5, who, 5);
        wait_grant(who); chk("R7 wraps to 4", who == 4, who, 4);
        drain();
        post(5, 'h10, 1'b0);
        wait_grant(who); chk("R7 single", who == 5, who, 5);
        drain();
        post(6, 'h00, 1'b0); post(4, 'h00, 1'b0); post(5, 'h00, 1'b0);
        wait_grant(who); chk("R7 next after 5 is 6", who == 6, who, 6);
        wait_grant(who); chk("R7 then 4", who == 4, who, 4);
        wait_grant(who); chk("R7 then 5", who == 5, who, 5);
        drain();

        // R8: sub-group alternation (last class 1 grant was sub-group A)
        post(0, 'h00, 1'b0); post(2, 'h00, 1'b0);
        wait_grant(who); chk("R8 B favoured", who == 2, who, 2);
        wait_grant(who); chk("R8 then A", who == 0, who, 0);
        drain();
        post(1, 'h00, 1'b0); post(3, 'h00, 1'b0);
        wait_grant(who); chk("R8 B favoured again", who == 3, who, 3);
        wait_grant(who); chk("R8 then A again", who == 1, who, 1);
        drain();

        // R4 and R9: busy module skipped, requester kept
        fbusy[1] = 1'b1;
        post(6, 'h04, 1'b0); post(7, 'h08, 1'b0);
        wait_grant(who); chk("R4 blocked requester skipped", who == 7, who, 7);
        drain();
        chk("R4 no grant to busy module", grant[6] == 1'b0, int'(grant[6]), 0);
        fbusy[1] = 1'b0;
        wait_grant(who); chk("R9 blocked requester granted later", who == 6, who, 6);
        chk("R9 start on module 1", mstart === 4'b0010, int'(mstart), 2);
        drain();

        // R2: repeat pulses ignored while pending and while granted
        post(8, 'h10, 1'b0);
        tick();
        post(8, 'h14, 1'b1);
        wait_grant(who);
        chk("R2 winner", who == 8, who, 8);
        chk("R2 first address kept", maddr[0 +: AW] == AW'('h10) && mstart === 4'b0001,
            int'(maddr[0 +: AW]), 'h10);
        post(8, 'h20, 1'b1);
        n = start_cnt;
        drain();
        chk("R2 pulse during grant ignored", start_cnt == n, start_cnt, n);

        // R5: four requests on four modules
        post(0, 'h00, 1'b0); post(2, 'h04, 1'b1); post(4, 'h08, 1'b0); post(8, 'h0C, 1'b1);
        repeat (4) tick();
        chk("R5 two accesses in flight", $countones(grant) == 2, $countones(grant), 2);
        drain(); drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule